// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Registers

This block is the digital front end of a two-channel 12-bit converter. A host drives a parallel data bus together with an active-low chip select and a channel select line. While chip select is low, bus words flow into the input register of the selected channel. A separate active-low load strobe for each channel then moves that channel's input register into its DAC register. The DAC register drives the converter code. Because the strobes are separate, a host can stage both channels first and then update them in a single cycle. It can also update one channel at a time, or hold a strobe low so that the channel passes input data straight through.

All host pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the level-sensitive capture is modelled by evaluating the synchronized pins on every clock edge. A pin-level clear input sets all four registers to code zero. Each channel reports a one-cycle update pulse whenever its code changes. The host interface is plain pins with no flow control: the bus is sampled on every cycle and nothing can stall it. A package function turns a code into its nominal output in millivolts so that checkers can use it.

Top module: `dual_dac_ctrl`

## Requirements
- R1: While synchronized chip select is low, the selected input register takes the synchronized bus value on every clock edge, so its last value is the final word seen before chip select rises.
- R2: While chip select is high, bus activity leaves both input registers unchanged.
- R3: `sel_b` low (0) routes bus data to channel A and high (1) routes it to channel B. The select is sampled on each cycle, so changing it partway through a chip-select window sends later words to the other channel. The unselected register is not changed.
- R4: A low pulse on `ld_a_n` copies input register A into DAC register A and leaves DAC register B unchanged. `ld_b_n` acts the same way for channel B.
- R5: If both strobes are pulsed low together, both DAC registers take their new values on the same clock edge.
- R6: While a strobe is held low, its DAC register tracks its input register continuously.
- R7: System reset `rst_n` low, or a synchronized low on the `clr_n` pin, clears both input registers and both DAC registers to code 0x000.
- R8: `upd_a` / `upd_b` is high for exactly one cycle, the first cycle a new code appears, whenever that channel's code changes. It stays low when a load writes the same value again.
- R9: Latency: a load strobe edge reaches the code output 3 clock edges after it is driven. With the strobe held low, a bus word reaches the code output 4 edges after it is driven.
- R10: Codes are unsigned straight binary at 1 mV per LSB. The helper `code_to_mv` maps 0x000 to 0, 0x7FF to 2047, 0x800 to 2048 and 0xFFF to 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_data | input | 12 | Parallel code bus from the host |
| cs_n | input | 1 | Active-low chip select; input register follows the bus while low |
| sel_b | input | 1 | Channel select: 0 = A, 1 = B |
| ld_a_n | input | 1 | Active-low load strobe for channel A |
| ld_b_n | input | 1 | Active-low load strobe for channel B |
| clr_n | input | 1 | Active-low pin clear of all registers |
| code_a | output | 12 | DAC register A code |
| code_b | output | 12 | DAC register B code |
| upd_a | output | 1 | One-cycle pulse when code_a changes |
| upd_b | output | 1 | One-cycle pulse when code_b changes |

## Verification
Some rules are checked on every cycle by the assertions:
- Input register capture, hold and routing against the synchronized pins.
- DAC register hold, load and clear.
- The match between each update pulse and an actual change of code.

Other behaviour can only be shown through the bench's scenarios at the ports:
- The end-to-end latency through the synchronizers.
- A select switch partway through a window.
- Simultaneous dual updates.
- Transparent tracking with a strobe held low.
- A clear that also empties the input registers.
- The millivolt mapping.

A seeded random sequence of writes and loads is compared against a bench model.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int CODE_W     = 12;
  localparam int MV_PER_LSB = 1;
  localparam int NUM_CH     = 2;

  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;

  // Nominal output in millivolts for a straight-binary code.
  function automatic int unsigned code_to_mv(logic [CODE_W-1:0] code);
    return int'(code) * MV_PER_LSB;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/in_reg_bank.sv
module in_reg_bank
  import dac_if_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cs,
  input  chan_e             sel,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] held [NUM_CH]
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic wr;
    assign wr = cs && (sel == chan_e'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held[ch] <= '0;
      else if (clr) held[ch] <= '0;
      else if (wr)  held[ch] <= data;
    end

    assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs) && $past(sel) == chan_e'(ch) && !$past(clr)) |-> held[ch] == $past(data));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cs) && !$past(clr)) |-> $stable(held[ch]));
    assert_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs) && $past(sel) != chan_e'(ch) && !$past(clr)) |-> $stable(held[ch]));
    assert_clear_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> held[ch] == '0);
  end
endmodule

// File: rtl/dac_reg.sv
module dac_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code,
  output logic              upd
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = code;
    if (clr)       nxt = '0;
    else if (load) nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      upd  <= 1'b0;
    end else begin
      code <= nxt;
      upd  <= (nxt != code);
    end
  end

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(clr)) |-> $stable(code));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && !$past(clr)) |-> code == $past(din));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> code == '0);
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd == (code != $past(code)));
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_if_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              cs_n,
  input  logic              sel_b,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  input  logic              clr_n,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              upd_a,
  output logic              upd_b
);
  localparam int CTRL_W = 5;
  localparam int PIN_W  = DATA_W + CTRL_W;
  // Control order {clr_n, ld_b_n, ld_a_n, sel_b, cs_n}; idle levels at reset.
  localparam logic [PIN_W-1:0] PIN_IDLE = {5'b11101, {DATA_W{1'b0}}};

  logic [PIN_W-1:0]  pins_q;
  logic [DATA_W-1:0] data_q;
  logic              cs_q, clr_q;
  chan_e             sel_q;
  logic [NUM_CH-1:0] load_q;
  logic [DATA_W-1:0] held [NUM_CH];
  logic [DATA_W-1:0] codes [NUM_CH];
  logic [NUM_CH-1:0] upds;

  pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({clr_n, ld_b_n, ld_a_n, sel_b, cs_n, bus_data}),
    .q    (pins_q)
  );

  assign data_q = pins_q[DATA_W-1:0];
  assign cs_q   = ~pins_q[DATA_W];
  assign sel_q  = chan_e'(pins_q[DATA_W+1]);
  assign load_q = ~pins_q[DATA_W+3:DATA_W+2];
  assign clr_q  = ~pins_q[DATA_W+4];

  in_reg_bank #(.DATA_W(DATA_W)) u_inbank (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_q),
    .cs   (cs_q),
    .sel  (sel_q),
    .data (data_q),
    .held (held)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dac
    dac_reg #(.DATA_W(DATA_W)) u_dac (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_q),
      .load (load_q[ch]),
      .din  (held[ch]),
      .code (codes[ch]),
      .upd  (upds[ch])
    );
  end

  assign code_a = codes[0];
  assign code_b = codes[1];
  assign upd_a  = upds[0];
  assign upd_b  = upds[1];

  assert_joint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(load_q) && !$past(clr_q)) |-> (code_a == $past(held[0]) && code_b == $past(held[1])));
endmodule

// File: tb/tb_dual_dac_ctrl.sv
module tb_dual_dac_ctrl;
  import dac_if_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_data = '0;
  logic        cs_n = 1'b1, sel_b = 1'b0, ld_a_n = 1'b1, ld_b_n = 1'b1, clr_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic        upd_a, upd_b;

  int checks = 0, errors = 0;
  int cnt_a = 0, cnt_b = 0, cnt_ab = 0;
  logic [11:0] m_in [2];
  logic [11:0] m_dac [2];

  always #4 clk = ~clk;

  dual_dac_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .cs_n(cs_n), .sel_b(sel_b),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .clr_n(clr_n),
    .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b)
  );

  always @(negedge clk) begin
    if (upd_a) cnt_a++;
    if (upd_b) cnt_b++;
    if (upd_a && upd_b) cnt_ab++;
  end

  function automatic int unsigned exp_mv(logic [11:0] c);
    return int'(c);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_ch(bit ch, logic [11:0] d);
    sel_b = ch; bus_data = d; cs_n = 1'b0;
    step(2);
    cs_n = 1'b1; bus_data = 12'($urandom);
    step(4);
    m_in[ch] = d;
  endtask

  task automatic load(bit a, bit b);
    ld_a_n = !a; ld_b_n = !b;
    step(1);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
    step(4);
    if (a) m_dac[0] = m_in[0];
    if (b) m_dac[1] = m_in[1];
  endtask

  task automatic cmp_codes(string req);
    check(req, code_a, m_dac[0]);
    check(req, code_b, m_dac[1]);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ba, bb, bab;
    void'($urandom(32'd7719));
    m_in[0] = '0; m_in[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    step(3);
    // R7: reset state
    check("R7 reset code_a", code_a, 0);
    check("R7 reset code_b", code_b, 0);
    check("R8 reset upd", {upd_a, upd_b}, 0);
    rst_n = 1'b1;
    step(2);

    // R1/R4: write A, load A only, B untouched
    write_ch(0, 12'hABC);
    ba = cnt_a;
    load(1, 0);
    cmp_codes("R4 independent load A");
    check("R8 one pulse on change", cnt_a - ba, 1);

    // R8: reload same value gives no pulse
    ba = cnt_a;
    load(1, 0);
    check("R8 no pulse on same value", cnt_a - ba, 0);

    // R1: bus changes during window, last word kept
    sel_b = 1'b1; cs_n = 1'b0;
    bus_data = 12'h111; step(2);
    bus_data = 12'h222; step(2);
    bus_data = 12'h3C5; step(2);
    cs_n = 1'b1; step(4);
    m_in[1] = 12'h3C5;
    load(0, 1);
    cmp_codes("R1 follow bus");

    // R2: bus activity with cs high ignored
    write_ch(0, 12'h123);
    for (int i = 0; i < 6; i++) begin bus_data = 12'($urandom); sel_b = i[0]; step(1); end
    load(1, 1);
    cmp_codes("R2 hold with cs high");

    // R3: select switch partway through window
    cs_n = 1'b0; sel_b = 1'b0; bus_data = 12'h5A5; step(3);
    sel_b = 1'b1; bus_data = 12'hA5A; step(3);
    cs_n = 1'b1; step(4);
    m_in[0] = 12'h5A5; m_in[1] = 12'hA5A;
    // R5: simultaneous update
    bab = cnt_ab;
    load(1, 1);
    cmp_codes("R3 mid-window redirect");
    check("R5 both updated same cycle", cnt_ab - bab, 1);

    // R9/R6: transparent mode with latency
    ld_a_n = 1'b0; step(4);
    sel_b = 1'b0; bus_data = 12'hE01; cs_n = 1'b0;
    step(3);
    check("R9 not yet at 3 edges", code_a, 12'h5A5);
    step(1);
    check("R9 code at 4 edges", code_a, 12'hE01);
    bus_data = 12'h0F7; step(4);
    check("R6 transparent tracking", code_a, 12'h0F7);
    cs_n = 1'b1; step(3);
    ld_a_n = 1'b1; step(3);
    m_in[0] = 12'h0F7; m_dac[0] = 12'h0F7;
    check("R6 held after release", code_a, 12'h0F7);

    // R9: load strobe latency 3 edges
    write_ch(1, 12'h777);
    ld_b_n = 1'b0; step(1); ld_b_n = 1'b1;
    step(1);
    check("R9 load not yet", code_b, 12'hA5A);
    step(1);
    check("R9 load at 3 edges", code_b, 12'h777);
    step(3);
    m_dac[1] = 12'h777;

    // R7: pin clear empties all four registers
    clr_n = 1'b0; step(1); clr_n = 1'b1; step(4);
    m_in[0] = '0; m_in[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    cmp_codes("R7 clear DAC");
    load(1, 1);
    cmp_codes("R7 clear input regs");

    // R10: millivolt mapping
    check("R10 mv 000", code_to_mv(12'h000), exp_mv(12'h000));
    check("R10 mv 7FF", code_to_mv(12'h7FF), 2047);
    check("R10 mv 800", code_to_mv(12'h800), 2048);
    check("R10 mv 801", code_to_mv(12'h801), exp_mv(12'h801));
    check("R10 mv FFF", code_to_mv(12'hFFF), 4095);

    // Random writes and loads against the model (R1 R3 R4 R5)
    for (int it = 0; it < 60; it++) begin
      bit ch, la, lb;
      ch = 1'($urandom);
      write_ch(ch, 12'($urandom));
      la = 1'($urandom); lb = 1'($urandom);
      if (la || lb) load(la, lb);
      cmp_codes("R4 random sequence");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule